// File: doc/BRIEF.md
# Write-Protect Command Sequencer

The sequencer sits between a byte-wide write bus and a page buffer. It watches every write cycle (address and data) for two fixed command strings. A short three-byte prefix arms the current page load for writing. A longer six-byte string switches the protection mode off. For each write it reports in the same cycle whether the byte was taken as a command byte and whether the byte may go on to the page buffer. A registered flag shows whether protection is active.

Protection is off after reset. It turns on only when the arming prefix is followed by at least one real data byte in the same load. While protection is on, data bytes pass only inside a load that began with the arming prefix. The permit ends when the load ends, which the surrounding logic signals with a one-cycle `load_end` pulse. Bytes that belong to the switch-off string are never passed on.

Top module: `wprot_seq`

## Requirements
- R1: After reset `protect_on` is 0, and no load is armed.
- R2: Command addresses are compared on address bits 14:0 only. The first byte of every string is 0xAA at 0x5555, and the second is 0x55 at 0x2AAA, which therefore also matches 0xAAAA. A matched byte raises `cmd_consumed` and keeps `wr_permit` low.
- R3: A third byte of 0xA0 at 0x5555 arms the load. If protection is off, the next write in that load is permitted, and `protect_on` reads 1 in the following cycle.
- R4: If `load_end` closes an armed load before any data byte arrives, `protect_on` stays 0.
- R5: While protection is on, a write in a load that is not armed gets `wr_permit` = 0.
- R6: In an armed load, every write is permitted and none is matched as a command. After `load_end`, the permit has to be earned again with a new prefix.
- R7: Switch-off string: a third byte of 0x80 at 0x5555, then 0xAA at 0x5555, 0x55 at 0x2AAA, and 0x20 at 0x5555. All six bytes are consumed and none is permitted. `protect_on` reads 0 in the cycle after the last byte.
- R8: A write that breaks a partly matched string returns the matcher to idle. That byte is not consumed, it is permitted only when protection is off, and it does not itself start a new string.
- R9: With protection off, a write that matches no string is permitted and leaves `protect_on` unchanged.
- R10: When `wr_valid` is 0, `wr_permit` and `cmd_consumed` are 0.
- R11: `load_end` also discards a partly matched string. It takes effect after the write that may share its cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | A write cycle is present this clock |
| wr_addr | input | 17 | Write address |
| wr_data | input | 8 | Write data |
| load_end | input | 1 | Current page load closes after this clock |
| protect_on | output | 1 | Protection mode active (registered) |
| wr_permit | output | 1 | Current byte may enter the page buffer |
| cmd_consumed | output | 1 | Current byte was taken as a command byte |

## Verification
A wrong match position shows up on the very write it affects: `cmd_consumed` and `wr_permit` are combinational on the current byte. So a missed or extra step is seen in the same cycle, or at the latest on the next byte of the string. A wrong protection state or arm state stays hidden until the next non-command write. That write is then refused or passed wrongly, and `protect_on` exposes an error in mode one cycle after the byte that should have changed it. Random command strings are mixed with noise, broken strings and loads that close early, so that each stale state is followed by a write that reveals it.

// File: rtl/wprot_seq.sv
module wprot_seq #(
  parameter int AW = 17,
  parameter int DW = 8,
  parameter int CW = 15,
  parameter logic [CW-1:0] ADDR_A = 15'h5555,
  parameter logic [CW-1:0] ADDR_B = 15'h2AAA,
  parameter logic [DW-1:0] CODE_LEAD = 8'hAA,
  parameter logic [DW-1:0] CODE_SECOND = 8'h55,
  parameter logic [DW-1:0] CODE_ARM = 8'hA0,
  parameter logic [DW-1:0] CODE_EXT = 8'h80,
  parameter logic [DW-1:0] CODE_CLEAR = 8'h20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          load_end,
  output logic          protect_on,
  output logic          wr_permit,
  output logic          cmd_consumed
);
  localparam int NSTEP = 6;
  localparam int SW = $clog2(NSTEP);
  localparam logic [SW-1:0] S_IDLE = SW'(0);
  localparam logic [SW-1:0] S_P1   = SW'(1);
  localparam logic [SW-1:0] S_P2   = SW'(2);
  localparam logic [SW-1:0] S_D3   = SW'(3);
  localparam logic [SW-1:0] S_D4   = SW'(4);
  localparam logic [SW-1:0] S_D5   = SW'(5);

  logic [SW-1:0] step_q, step_nx;
  logic armed_q, prot_q;
  logic step_hit, arm_set, clr_done;

  wire [CW-1:0] alo = wr_addr[CW-1:0];
  wire at_a = (alo == ADDR_A);
  wire at_b = (alo == ADDR_B);
  wire hit_lead   = at_a && (wr_data == CODE_LEAD);
  wire hit_second = at_b && (wr_data == CODE_SECOND);
  wire hit_arm    = at_a && (wr_data == CODE_ARM);
  wire hit_ext    = at_a && (wr_data == CODE_EXT);
  wire hit_clear  = at_a && (wr_data == CODE_CLEAR);
  wire matching   = wr_valid && !armed_q;

  always_comb begin
    step_hit = 1'b0;
    arm_set  = 1'b0;
    clr_done = 1'b0;
    step_nx  = S_IDLE;
    case (step_q)
      S_IDLE: if (hit_lead)   begin step_hit = 1'b1; step_nx = S_P1; end
      S_P1:   if (hit_second) begin step_hit = 1'b1; step_nx = S_P2; end
      S_P2: begin
        if (hit_arm) begin
          step_hit = 1'b1;
          arm_set  = 1'b1;
        end else if (hit_ext) begin
          step_hit = 1'b1;
          step_nx  = S_D3;
        end
      end
      S_D3:   if (hit_lead)   begin step_hit = 1'b1; step_nx = S_D4; end
      S_D4:   if (hit_second) begin step_hit = 1'b1; step_nx = S_D5; end
      S_D5:   if (hit_clear)  begin step_hit = 1'b1; clr_done = 1'b1; end
      default: step_nx = S_IDLE;
    endcase
  end

  assign cmd_consumed = matching && step_hit;
  assign wr_permit    = wr_valid && (armed_q || (!step_hit && !prot_q));
  assign protect_on   = prot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q  <= S_IDLE;
      armed_q <= 1'b0;
      prot_q  <= 1'b0;
    end else begin
      if (matching) step_q <= step_nx;
      if (matching && arm_set) armed_q <= 1'b1;
      if (wr_valid && armed_q && !prot_q) prot_q <= 1'b1;
      if (matching && clr_done) prot_q <= 1'b0;
      if (load_end) begin
        armed_q <= 1'b0;
        step_q  <= S_IDLE;
      end
    end
  end
endmodule

// File: rtl/wprot_seq_chk.sv
module wprot_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_valid,
  input logic [7:0] wr_data,
  input logic       protect_on,
  input logic       wr_permit,
  input logic       cmd_consumed
);
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> (!wr_permit && !cmd_consumed));
  a_r2_cmd_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_consumed |-> !wr_permit);
  a_r3_rise_on_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(protect_on) |-> $past(wr_valid && wr_permit && !cmd_consumed));
  a_r7_fall_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(protect_on) |-> $past(cmd_consumed && wr_data == 8'h20));
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_valid) |-> $stable(protect_on));
endmodule

bind wprot_seq wprot_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
  .protect_on(protect_on), .wr_permit(wr_permit), .cmd_consumed(cmd_consumed)
);

// File: tb/wprot_seq_bench.sv
module wprot_seq_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic load_end = 1'b0;
  logic protect_on, wr_permit, cmd_consumed;

  int checks = 0;
  int errors = 0;
  int m_step = 0;
  bit m_prot = 1'b0;
  bit m_arm = 1'b0;

  always #4 clk = ~clk;

  wprot_seq u_wprot_seq (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .load_end(load_end), .protect_on(protect_on),
    .wr_permit(wr_permit), .cmd_consumed(cmd_consumed)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [16:0] at_lo(input logic [14:0] lo);
    logic [1:0] hi = 2'($urandom_range(0, 3));
    return {hi, lo};
  endfunction

  task automatic cyc(input bit v, input logic [16:0] a, input logic [7:0] d, input bit le, input string tag);
    bit ep, ec, np, na, la, lb;
    int ns;
    string t;
    @(negedge clk);
    wr_valid = v; wr_addr = a; wr_data = d; load_end = le;
    #1;
    ep = 0; ec = 0; ns = m_step; np = m_prot; na = m_arm; t = "R10";
    la = (a[14:0] == 15'h5555);
    lb = (a[14:0] == 15'h2AAA);
    if (v) begin
      if (m_arm) begin
        ep = 1; t = "R6";
        if (!m_prot) begin np = 1; t = "R3"; end
      end else begin
        case (m_step)
          0: if (la && d == 8'hAA) begin ec = 1; ns = 1; end
          1: if (lb && d == 8'h55) begin ec = 1; ns = 2; end
          2: if (la && d == 8'hA0) begin ec = 1; ns = 0; na = 1; end
             else if (la && d == 8'h80) begin ec = 1; ns = 3; end
          3: if (la && d == 8'hAA) begin ec = 1; ns = 4; end
          4: if (lb && d == 8'h55) begin ec = 1; ns = 5; end
          5: if (la && d == 8'h20) begin ec = 1; ns = 0; np = 0; end
          default: ;
        endcase
        if (!ec) begin
          ep = !m_prot; ns = 0;
          t = (m_step != 0) ? "R8" : (m_prot ? "R5" : "R9");
        end else begin
          t = (m_step >= 3 || (m_step == 2 && d == 8'h80)) ? "R7" : "R2";
        end
      end
    end
    if (le) begin na = 0; ns = 0; end
    if (tag != "") t = tag;
    chk(wr_permit === ep, t, "wr_permit", int'(wr_permit), int'(ep));
    chk(cmd_consumed === ec, t, "cmd_consumed", int'(cmd_consumed), int'(ec));
    m_step = ns; m_prot = np; m_arm = na;
    @(posedge clk); #1;
    chk(protect_on === m_prot, t, "protect_on", int'(protect_on), int'(m_prot));
  endtask

  task automatic prefix(input string tag);
    cyc(1, at_lo(15'h5555), 8'hAA, 0, tag);
    cyc(1, at_lo(15'h2AAA), 8'h55, 0, tag);
    cyc(1, at_lo(15'h5555), 8'hA0, 0, tag);
  endtask

  task automatic switch_off(input string tag);
    cyc(1, at_lo(15'h5555), 8'hAA, 0, tag);
    cyc(1, at_lo(15'h2AAA), 8'h55, 0, tag);
    cyc(1, at_lo(15'h5555), 8'h80, 0, tag);
    cyc(1, at_lo(15'h5555), 8'hAA, 0, tag);
    cyc(1, at_lo(15'h2AAA), 8'h55, 0, tag);
    cyc(1, at_lo(15'h5555), 8'h20, 0, tag);
  endtask

  task automatic close_load();
    cyc(0, '0, '0, 1, "R11");
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(posedge clk);
    #1;
    chk(protect_on === 1'b0, "R1", "protect_on after reset", int'(protect_on), 0);
    @(negedge clk); rst_n = 1'b1;

    cyc(1, 17'h01234, 8'h3C, 0, "R9");
    cyc(0, 17'h05555, 8'hAA, 0, "R10");
    prefix("R2");
    close_load();
    cyc(0, '0, '0, 0, "R4");
    cyc(1, 17'h00100, 8'h11, 0, "R9");
    close_load();
    prefix("R3");
    cyc(1, 17'h00200, 8'h22, 0, "R3");
    cyc(1, 17'h00201, 8'h23, 1, "R6");
    cyc(1, 17'h00300, 8'h33, 0, "R5");
    close_load();
    cyc(1, 17'h0AAAA, 8'hAA, 0, "R5");
    cyc(1, 17'h15555, 8'hAA, 0, "R2");
    cyc(1, 17'h0AAAA, 8'h55, 0, "R2");
    cyc(1, 17'h05555, 8'hA0, 0, "R6");
    cyc(1, 17'h05555, 8'hAA, 0, "R6");
    cyc(1, 17'h00400, 8'h44, 1, "R6");
    cyc(1, 17'h00401, 8'h45, 0, "R6");
    cyc(1, 17'h05555, 8'hAA, 0, "R8");
    cyc(1, 17'h05555, 8'hAA, 0, "R8");
    cyc(1, 17'h02AAA, 8'h55, 0, "R8");
    cyc(1, 17'h05555, 8'hAA, 0, "R11");
    cyc(1, 17'h02AAA, 8'h55, 1, "R11");
    cyc(1, 17'h05555, 8'hA0, 0, "R11");
    close_load();
    switch_off("R7");
    cyc(1, 17'h00500, 8'h55, 0, "R9");
    close_load();

    for (int it = 0; it < 2500; it++) begin
      int kind = $urandom_range(0, 5);
      case (kind)
        0: begin
          prefix("");
          for (int k = 0; k < $urandom_range(1, 4); k++)
            cyc(1, 17'($urandom), 8'($urandom), 0, "");
          close_load();
        end
        1: begin switch_off(""); close_load(); end
        2: begin
          for (int k = 0; k < $urandom_range(1, 3); k++)
            cyc($urandom_range(0, 3) != 0, 17'($urandom), 8'($urandom), 0, "");
        end
        3: begin
          cyc(1, at_lo(15'h5555), 8'hAA, 0, "");
          cyc(1, 17'($urandom), 8'($urandom), 0, "");
        end
        4: begin prefix(""); close_load(); end
        default: begin
          cyc(1, at_lo(15'h5555), 8'hAA, 0, "");
          cyc(1, at_lo(15'h2AAA), 8'h55, 0, "");
          cyc(1, at_lo(15'h5555), 8'h80, 0, "");
          cyc(1, at_lo(15'h5555), 8'hAA, 0, "");
          cyc(1, 17'($urandom), 8'($urandom), $urandom_range(0, 1) == 1, "");
        end
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule